// File: doc/BRIEF.md
# Page Table Walk Start Calculator

This block prepares the first memory access of a multi-level page table walk. For each request it takes a 64-bit virtual address, a privilege tier, the table-size, granule and walk-disable settings of both address halves, and two 48-bit table base registers. It returns, one cycle after acceptance, whether the address faults, which base register applies, the granule as its log2 value, the level the walk starts at, and the 48-bit physical address of the first descriptor to fetch.

The request side and the response side each use a valid/ready pair. The inputs are read only in the cycle a request is accepted. A single registered output slot holds the result. A small state machine has two states: `ST_EMPTY` (no result held) and `ST_FULL` (a result is presented). There are four transitions. `ST_EMPTY -> ST_FULL` is *load*, on an accepted request. `ST_FULL -> ST_FULL` is either *stall*, when the result is not taken, or *reload*, when the result is taken and a new request is accepted in the same cycle. `ST_FULL -> ST_EMPTY` is *drain*, when the result is taken and no request arrives. Because of this, a new request is accepted while a result is being taken, and the block runs at one result per cycle.

Top module: `walk_start_calc`

## Requirements
- R1: At tier 0 (`req_priv` = 0), VA[63:48] = 0x0000 selects the lower base register (`rsp_sel_hi` = 0). VA[63:48] = 0xFFFF selects the upper one (`rsp_sel_hi` = 1). Any other value faults, with `rsp_sel_hi` = 0.
- R2: The lower-half granule code maps 0 to 12, 1 to 16, 2 to 14, and 3 (reserved) to 12. The value is reported on `rsp_gran` as a log2 size.
- R3: The upper-half granule code maps 0 (reserved) to 12, 1 to 14, 2 to 12 and 3 to 16.
- R4: The effective width W is 64 minus the selected half's size field, clamped into 25..48.
- R5: At tier 0, the lower half faults when any VA bit at or above W is set, or when `cfg_lo_off` = 1. The upper half faults when any VA bit at or above W is clear, or when `cfg_hi_off` = 1.
- R6: At tiers 1..3 only the lower register and the lower size/granule fields apply. The block faults exactly when VA[63:48] is not zero; the walk-disable bits and VA bits [47:W] have no effect.
- R7: With stride S = granule − 3, the start level is the first L in 0..2 whose cutoff is below W, else level 3. The cutoffs are: granule 12: {39, 30, 0}; granule 14: {47, 36, 25}; granule 16: {64, 42, 29}.
- R8: When there is no fault, `rsp_desc_addr` is formed in two steps. First, base bits [47:B] are kept, where B = 3 + W − S·(3−L) − granule. Then VA bits [W−1 : S·(3−L)+granule] are ORed in, placed from bit 3 upward.
- R9: On a fault, `rsp_desc_addr` is zero.
- R10: `req_ready` is high whenever no result is held or the held result is taken. An accepted request's result is valid at the next clock edge. A result not taken stays valid and unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_va | input | 64 | Virtual address |
| req_priv | input | 2 | Privilege tier, 0 = lowest |
| cfg_lo_size | input | 6 | Lower-half size field |
| cfg_hi_size | input | 6 | Upper-half size field |
| cfg_lo_gran | input | 2 | Lower-half granule code |
| cfg_hi_gran | input | 2 | Upper-half granule code |
| cfg_lo_off | input | 1 | Lower-half walk disable |
| cfg_hi_off | input | 1 | Upper-half walk disable |
| tbl_lo_base | input | 48 | Lower table base register |
| tbl_hi_base | input | 48 | Upper table base register |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Result taken |
| rsp_fault | output | 1 | Translation fault |
| rsp_sel_hi | output | 1 | Upper base register selected |
| rsp_gran | output | 5 | Granule as log2 bytes |
| rsp_level | output | 2 | Starting lookup level |
| rsp_desc_addr | output | 48 | First descriptor address |

## Verification
The assertions assume that `req_priv` is valid in any cycle where `req_valid` and `req_ready` are both high. They also assume that `rsp_ready` may change freely from cycle to cycle, and they place no other limit on the data inputs. The stimulus drives all request fields together with `req_valid` and holds them until acceptance. It drives `rsp_ready` independently, in stretches of backpressure, so the stall, reload and drain transitions all occur. Directed requests sit on every level cutoff and every clamp edge, and a pseudo-random run mixes address tags, widths and granule codes across all tiers.

// File: rtl/walk_pkg.sv
package walk_pkg;

    localparam int unsigned GRAN_W = 5;
    typedef logic [GRAN_W-1:0] gran_t;

    localparam gran_t GRAN_4K  = 5'd12;
    localparam gran_t GRAN_16K = 5'd14;
    localparam gran_t GRAN_64K = 5'd16;

    typedef enum logic [1:0] {LVL0 = 2'd0, LVL1 = 2'd1, LVL2 = 2'd2, LVL3 = 2'd3} level_e;

    typedef enum logic {ST_EMPTY = 1'b0, ST_FULL = 1'b1} slot_e;

    // lower-half code: 0->4K, 1->64K, 2->16K, 3 reserved (4K)
    function automatic gran_t decode_lo_gran(input logic [1:0] code);
        gran_t g;
        unique case (code)
            2'd0:    g = GRAN_4K;
            2'd1:    g = GRAN_64K;
            2'd2:    g = GRAN_16K;
            default: g = GRAN_4K;
        endcase
        return g;
    endfunction

    // upper-half code: 0 reserved (4K), 1->16K, 2->4K, 3->64K
    function automatic gran_t decode_hi_gran(input logic [1:0] code);
        gran_t g;
        unique case (code)
            2'd1:    g = GRAN_16K;
            2'd2:    g = GRAN_4K;
            2'd3:    g = GRAN_64K;
            default: g = GRAN_4K;
        endcase
        return g;
    endfunction

    // width must exceed this value for the walk to start at level lvl
    function automatic logic [6:0] level_cutoff(input gran_t g, input int unsigned lvl);
        logic [6:0] c;
        c = 7'd0;
        if (g == GRAN_16K) begin
            unique case (lvl)
                0:       c = 7'd47;
                1:       c = 7'd36;
                default: c = 7'd25;
            endcase
        end else if (g == GRAN_64K) begin
            unique case (lvl)
                0:       c = 7'd64;
                1:       c = 7'd42;
                default: c = 7'd29;
            endcase
        end else begin
            unique case (lvl)
                0:       c = 7'd39;
                1:       c = 7'd30;
                default: c = 7'd0;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/walk_region_sel.sv
module walk_region_sel
    import walk_pkg::*;
#(
    parameter int unsigned VA_W    = 64,
    parameter int unsigned PA_W    = 48,
    parameter int unsigned SIZE_W  = 6,
    parameter int unsigned WID_MIN = 25,
    parameter int unsigned WID_MAX = 48,
    parameter int unsigned WID_W   = 7
) (
    input  logic [VA_W-1:0]   va,
    input  logic [1:0]        priv,
    input  logic [SIZE_W-1:0] lo_size,
    input  logic [SIZE_W-1:0] hi_size,
    input  logic [1:0]        lo_gran,
    input  logic [1:0]        hi_gran,
    input  logic              lo_off,
    input  logic              hi_off,
    output logic              sel_hi,
    output logic              fault,
    output gran_t             gran,
    output logic [WID_W-1:0]  width
);

    localparam int unsigned TAG_W = VA_W - PA_W;

    logic [TAG_W-1:0]  tag;
    logic              low_tier;
    logic              tag_zero;
    logic              tag_ones;
    logic [SIZE_W-1:0] size_pick;
    logic [WID_W-1:0]  raw_width;
    logic [VA_W-1:0]   one_v;
    logic [VA_W-1:0]   above_mask;
    logic [VA_W-1:0]   above_bits;

    assign tag      = va[VA_W-1:PA_W];
    assign low_tier = (priv == 2'd0);
    assign tag_zero = (tag == '0);
    assign tag_ones = (&tag);
    assign one_v    = {{(VA_W-1){1'b0}}, 1'b1};

    always_comb begin
        sel_hi    = low_tier && tag_ones;
        size_pick = sel_hi ? hi_size : lo_size;
        raw_width = WID_W'(VA_W) - WID_W'(size_pick);
        if (raw_width > WID_W'(WID_MAX)) begin
            width = WID_W'(WID_MAX);
        end else if (raw_width < WID_W'(WID_MIN)) begin
            width = WID_W'(WID_MIN);
        end else begin
            width = raw_width;
        end
        gran       = sel_hi ? decode_hi_gran(hi_gran) : decode_lo_gran(lo_gran);
        above_mask = ~((one_v << width) - one_v);
        above_bits = va & above_mask;
        if (!low_tier) begin
            fault = !tag_zero;
        end else if (tag_zero) begin
            fault = (above_bits != '0) || lo_off;
        end else if (tag_ones) begin
            fault = (above_bits != above_mask) || hi_off;
        end else begin
            fault = 1'b1;
        end
    end

endmodule

// File: rtl/walk_level_pick.sv
module walk_level_pick
    import walk_pkg::*;
#(
    parameter int unsigned WID_W    = 7,
    parameter int unsigned N_CUTOFF = 3
) (
    input  gran_t            gran,
    input  logic [WID_W-1:0] width,
    output level_e           level
);

    logic [N_CUTOFF-1:0] exceed;

    for (genvar i = 0; i < N_CUTOFF; i++) begin : g_cut
        assign exceed[i] = (width > WID_W'(level_cutoff(gran, i)));
    end

    always_comb begin
        if (exceed[0]) begin
            level = LVL0;
        end else if (exceed[1]) begin
            level = LVL1;
        end else if (exceed[2]) begin
            level = LVL2;
        end else begin
            level = LVL3;
        end
    end

endmodule

// File: rtl/walk_addr_gen.sv
module walk_addr_gen
    import walk_pkg::*;
#(
    parameter int unsigned VA_W  = 64,
    parameter int unsigned PA_W  = 48,
    parameter int unsigned WID_W = 7,
    parameter int unsigned DESC_SHIFT = 3
) (
    input  logic [VA_W-1:0]  va,
    input  logic [PA_W-1:0]  base,
    input  gran_t            gran,
    input  logic [WID_W-1:0] width,
    input  level_e           level,
    input  logic             fault,
    output logic [PA_W-1:0]  desc_addr
);

    logic [WID_W-1:0] stride;
    logic [WID_W-1:0] lvl_gap;
    logic [WID_W-1:0] idx_lsb;
    logic [WID_W-1:0] base_lsb;
    logic [PA_W-1:0]  one_p;
    logic [PA_W-1:0]  width_mask;
    logic [PA_W-1:0]  base_mask;
    logic [PA_W-1:0]  index;

    assign one_p = {{(PA_W-1){1'b0}}, 1'b1};

    always_comb begin
        stride     = WID_W'(gran) - WID_W'(DESC_SHIFT);
        lvl_gap    = WID_W'(2'd3 - 2'(level));
        idx_lsb    = WID_W'(stride * lvl_gap) + WID_W'(gran);
        base_lsb   = width + WID_W'(DESC_SHIFT) - idx_lsb;
        width_mask = (one_p << width) - one_p;
        base_mask  = ~((one_p << base_lsb) - one_p);
        index      = (va[PA_W-1:0] & width_mask) >> idx_lsb;
        if (fault) begin
            desc_addr = '0;
        end else begin
            desc_addr = (base & base_mask) | (index << DESC_SHIFT);
        end
    end

endmodule

// File: rtl/walk_start_calc.sv
module walk_start_calc
    import walk_pkg::*;
#(
    parameter int unsigned VA_W    = 64,
    parameter int unsigned PA_W    = 48,
    parameter int unsigned SIZE_W  = 6,
    parameter int unsigned WID_MIN = 25,
    parameter int unsigned WID_MAX = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_va,
    input  logic [1:0]        req_priv,
    input  logic [SIZE_W-1:0] cfg_lo_size,
    input  logic [SIZE_W-1:0] cfg_hi_size,
    input  logic [1:0]        cfg_lo_gran,
    input  logic [1:0]        cfg_hi_gran,
    input  logic              cfg_lo_off,
    input  logic              cfg_hi_off,
    input  logic [PA_W-1:0]   tbl_lo_base,
    input  logic [PA_W-1:0]   tbl_hi_base,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic              rsp_fault,
    output logic              rsp_sel_hi,
    output logic [4:0]        rsp_gran,
    output logic [1:0]        rsp_level,
    output logic [PA_W-1:0]   rsp_desc_addr
);

    localparam int unsigned WID_W = $clog2(VA_W + 1);

    slot_e            state_q;
    slot_e            state_d;
    logic             accept;
    logic             sel_hi_c;
    logic             fault_c;
    gran_t            gran_c;
    logic [WID_W-1:0] width_c;
    level_e           level_c;
    logic [PA_W-1:0]  desc_c;
    logic [PA_W-1:0]  base_c;

    walk_region_sel #(
        .VA_W(VA_W), .PA_W(PA_W), .SIZE_W(SIZE_W),
        .WID_MIN(WID_MIN), .WID_MAX(WID_MAX), .WID_W(WID_W)
    ) u_region (
        .va(req_va), .priv(req_priv),
        .lo_size(cfg_lo_size), .hi_size(cfg_hi_size),
        .lo_gran(cfg_lo_gran), .hi_gran(cfg_hi_gran),
        .lo_off(cfg_lo_off), .hi_off(cfg_hi_off),
        .sel_hi(sel_hi_c), .fault(fault_c), .gran(gran_c), .width(width_c)
    );

    walk_level_pick #(.WID_W(WID_W), .N_CUTOFF(3)) u_level (
        .gran(gran_c), .width(width_c), .level(level_c)
    );

    assign base_c = sel_hi_c ? tbl_hi_base : tbl_lo_base;

    walk_addr_gen #(.VA_W(VA_W), .PA_W(PA_W), .WID_W(WID_W), .DESC_SHIFT(3)) u_addr (
        .va(req_va), .base(base_c), .gran(gran_c), .width(width_c),
        .level(level_c), .fault(fault_c), .desc_addr(desc_c)
    );

    assign req_ready = (state_q == ST_EMPTY) || rsp_ready;
    assign accept    = req_valid && req_ready;
    assign rsp_valid = (state_q == ST_FULL);

    // next-state: load, stall, reload, drain
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (accept) state_d = ST_FULL;
            ST_FULL:  if (rsp_ready && !req_valid) state_d = ST_EMPTY;
            default:  state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_fault     <= 1'b0;
            rsp_sel_hi    <= 1'b0;
            rsp_gran      <= '0;
            rsp_level     <= '0;
            rsp_desc_addr <= '0;
        end else if (accept) begin
            rsp_fault     <= fault_c;
            rsp_sel_hi    <= sel_hi_c;
            rsp_gran      <= gran_c;
            rsp_level     <= 2'(level_c);
            rsp_desc_addr <= desc_c;
        end
    end

endmodule

// File: rtl/walk_start_chk.sv
module walk_start_chk #(
    parameter int unsigned PA_W = 48
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic [1:0]      req_priv,
    input logic            rsp_valid,
    input logic            rsp_ready,
    input logic            rsp_fault,
    input logic            rsp_sel_hi,
    input logic [4:0]      rsp_gran,
    input logic [1:0]      rsp_level,
    input logic [PA_W-1:0] rsp_desc_addr
);

    a_r10_empty_takes: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> req_ready);

    a_r10_load_next: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);

    a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_desc_addr) &&
            $stable(rsp_fault) && $stable(rsp_sel_hi) && $stable(rsp_gran) &&
            $stable(rsp_level)));

    a_r6_lower_only: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_priv != 2'd0) |=> !rsp_sel_hi);

    a_r9_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_desc_addr == '0));

    a_r2_gran_legal: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_gran == 5'd12 || rsp_gran == 5'd14 || rsp_gran == 5'd16));

    a_r7_no_l0_64k: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault && rsp_gran == 5'd16) |-> (rsp_level != 2'd0));

    a_r8_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_desc_addr[2:0] == 3'b000));

endmodule

bind walk_start_calc walk_start_chk #(.PA_W(PA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_priv(req_priv), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_fault(rsp_fault), .rsp_sel_hi(rsp_sel_hi), .rsp_gran(rsp_gran),
    .rsp_level(rsp_level), .rsp_desc_addr(rsp_desc_addr)
);

// File: tb/walk_start_calc_tb_top.sv
module walk_start_calc_tb_top;

    typedef struct packed {
        logic        fault;
        logic        sel_hi;
        logic [4:0]  gran;
        logic [1:0]  level;
        logic [47:0] desc;
    } exp_t;

    int unsigned n_checks = 0;
    int unsigned n_fails  = 0;
    logic        done     = 1'b0;
    logic        bp_on    = 1'b0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_va = '0;
    logic [1:0]  req_priv = '0;
    logic [5:0]  cfg_lo_size = '0;
    logic [5:0]  cfg_hi_size = '0;
    logic [1:0]  cfg_lo_gran = '0;
    logic [1:0]  cfg_hi_gran = '0;
    logic        cfg_lo_off = 1'b0;
    logic        cfg_hi_off = 1'b0;
    logic [47:0] tbl_lo_base = 48'h1234_5678_9ABC;
    logic [47:0] tbl_hi_base = 48'hFEDC_BA98_7654;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic        rsp_fault;
    logic        rsp_sel_hi;
    logic [4:0]  rsp_gran;
    logic [1:0]  rsp_level;
    logic [47:0] rsp_desc_addr;

    exp_t  q_exp[$];
    string q_tag[$];

    always #4 clk = ~clk;

    walk_start_calc dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_va(req_va), .req_priv(req_priv),
        .cfg_lo_size(cfg_lo_size), .cfg_hi_size(cfg_hi_size),
        .cfg_lo_gran(cfg_lo_gran), .cfg_hi_gran(cfg_hi_gran),
        .cfg_lo_off(cfg_lo_off), .cfg_hi_off(cfg_hi_off),
        .tbl_lo_base(tbl_lo_base), .tbl_hi_base(tbl_hi_base),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_fault(rsp_fault),
        .rsp_sel_hi(rsp_sel_hi), .rsp_gran(rsp_gran), .rsp_level(rsp_level),
        .rsp_desc_addr(rsp_desc_addr)
    );

    task automatic check(input string tag, input logic ok, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    // requirement-level model, written from the brief
    function automatic exp_t model(input logic [63:0] va, input logic [1:0] priv,
                                   input logic [5:0] losz, input logic [5:0] hisz,
                                   input logic [1:0] log_c, input logic [1:0] hig_c,
                                   input logic looff, input logic hioff,
                                   input logic [47:0] lob, input logic [47:0] hib);
        exp_t e;
        int w, g, lvl, s, sh, lo;
        int cut[3];
        logic [47:0] b;
        logic [15:0] tag;
        e = '0;
        tag = va[63:48];
        if (priv == 2'd0) begin
            if (tag == 16'h0000) e.sel_hi = 1'b0;
            else if (tag == 16'hFFFF) e.sel_hi = 1'b1;
            else e.fault = 1'b1;
        end else begin
            e.fault = (tag != 16'h0000);
        end
        w = 64 - int'(e.sel_hi ? hisz : losz);
        if (w > 48) w = 48;
        if (w < 25) w = 25;
        if (e.sel_hi) g = (hig_c == 2'd1) ? 14 : (hig_c == 2'd3) ? 16 : 12;
        else          g = (log_c == 2'd1) ? 16 : (log_c == 2'd2) ? 14 : 12;
        if (priv == 2'd0 && !e.fault) begin
            for (int i = w; i < 64; i++) begin
                if (!e.sel_hi && va[i]) e.fault = 1'b1;
                if (e.sel_hi && !va[i]) e.fault = 1'b1;
            end
            if (!e.sel_hi && looff) e.fault = 1'b1;
            if (e.sel_hi && hioff) e.fault = 1'b1;
        end
        if (g == 12) cut = '{39, 30, 0};
        else if (g == 14) cut = '{47, 36, 25};
        else cut = '{64, 42, 29};
        lvl = 3;
        for (int i = 2; i >= 0; i--) if (w > cut[i]) lvl = i;
        s  = g - 3;
        sh = s * (3 - lvl) + g;
        lo = 3 + w - s * (3 - lvl) - g;
        b  = e.sel_hi ? hib : lob;
        for (int i = lo; i < 48; i++) e.desc[i] = b[i];
        for (int i = sh; i < w; i++) e.desc[i - sh + 3] = e.desc[i - sh + 3] | va[i];
        if (e.fault) e.desc = '0;
        e.gran  = 5'(g);
        e.level = 2'(lvl);
        return e;
    endfunction

    task automatic send(input string tag, input logic [63:0] va, input logic [1:0] priv,
                        input logic [5:0] losz, input logic [5:0] hisz,
                        input logic [1:0] log_c, input logic [1:0] hig_c,
                        input logic looff, input logic hioff);
        logic got;
        @(negedge clk);
        req_va = va; req_priv = priv; cfg_lo_size = losz; cfg_hi_size = hisz;
        cfg_lo_gran = log_c; cfg_hi_gran = hig_c; cfg_lo_off = looff; cfg_hi_off = hioff;
        req_valid = 1'b1;
        forever begin
            #1 got = req_ready;
            @(posedge clk);
            if (got) break;
            @(negedge clk);
        end
        q_exp.push_back(model(va, priv, losz, hisz, log_c, hig_c, looff, hioff,
                              tbl_lo_base, tbl_hi_base));
        q_tag.push_back(tag);
        @(negedge clk);
        req_valid = 1'b0;
        #1 check("R10 result valid after accept", rsp_valid == 1'b1, 64'(rsp_valid), 64'd1);
    endtask

    // response backpressure
    initial begin
        forever begin
            @(negedge clk);
            rsp_ready = bp_on ? (($urandom % 4) != 0) : 1'b1;
        end
    end

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (rst_n && rsp_valid && rsp_ready) begin
                if (q_exp.size() == 0) begin
                    check("R10 unexpected result", 1'b0, 64'(rsp_desc_addr), 64'd0);
                end else begin
                    exp_t  e;
                    string t;
                    exp_t  a;
                    e = q_exp.pop_front();
                    t = q_tag.pop_front();
                    a = '{rsp_fault, rsp_sel_hi, rsp_gran, rsp_level, rsp_desc_addr};
                    if (e.fault) begin
                        check(t, a.fault && a.sel_hi == e.sel_hi && a.desc == '0,
                              64'(a), 64'(e));
                    end else begin
                        check(t, a == e, 64'(a), 64'(e));
                    end
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_up();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R10 reset no result", rsp_valid == 1'b0, 64'(rsp_valid), 64'd0);
        check("R10 reset ready", req_ready == 1'b1, 64'(req_ready), 64'd1);

        // R1, R2: lower half, each granule code, width 48
        send("R2 lower 4K",        64'h0000_8123_4567_8000, 2'd0, 6'd16, 6'd16, 2'd0, 2'd0, 1'b0, 1'b0);
        send("R2 lower 64K",       64'h0000_8123_4567_8000, 2'd0, 6'd16, 6'd16, 2'd1, 2'd0, 1'b0, 1'b0);
        send("R2 lower 16K",       64'h0000_8123_4567_8000, 2'd0, 6'd16, 6'd16, 2'd2, 2'd0, 1'b0, 1'b0);
        send("R2 lower reserved",  64'h0000_8123_4567_8000, 2'd0, 6'd16, 6'd16, 2'd3, 2'd0, 1'b0, 1'b0);
        // R1, R3: upper half codes
        send("R3 upper reserved",  64'hFFFF_9ABC_DEF0_1000, 2'd0, 6'd16, 6'd16, 2'd0, 2'd0, 1'b0, 1'b0);
        send("R3 upper 16K",       64'hFFFF_9ABC_DEF0_1000, 2'd0, 6'd16, 6'd16, 2'd0, 2'd1, 1'b0, 1'b0);
        send("R3 upper 4K",        64'hFFFF_9ABC_DEF0_1000, 2'd0, 6'd16, 6'd16, 2'd0, 2'd2, 1'b0, 1'b0);
        send("R3 upper 64K",       64'hFFFF_9ABC_DEF0_1000, 2'd0, 6'd16, 6'd16, 2'd0, 2'd3, 1'b0, 1'b0);
        send("R1 bad tag",         64'h1234_0000_0000_0000, 2'd0, 6'd16, 6'd16, 2'd0, 2'd0, 1'b0, 1'b0);
        // R5
        send("R5 lower out of range", 64'h0000_0100_0000_0000, 2'd0, 6'd25, 6'd16, 2'd0, 2'd0, 1'b0, 1'b0);
        send("R5 lower disabled",  64'h0000_0000_0000_1000, 2'd0, 6'd16, 6'd16, 2'd0, 2'd0, 1'b1, 1'b0);
        send("R5 upper disabled",  64'hFFFF_FFFF_0000_1000, 2'd0, 6'd16, 6'd16, 2'd0, 2'd2, 1'b0, 1'b1);
        send("R5 upper hole",      64'hFFFF_DFFF_0000_0000, 2'd0, 6'd16, 6'd25, 2'd0, 2'd2, 1'b0, 1'b0);
        send("R5 upper in range",  64'hFFFF_FF80_1234_5000, 2'd0, 6'd16, 6'd25, 2'd0, 2'd2, 1'b0, 1'b0);
        // R4 clamp edges
        send("R4 clamp high",      64'h0000_8000_0000_0000, 2'd0, 6'd0,  6'd0,  2'd0, 2'd0, 1'b0, 1'b0);
        send("R4 clamp low 16K",   64'h0000_0000_01FF_C000, 2'd0, 6'd63, 6'd0,  2'd2, 2'd0, 1'b0, 1'b0);
        send("R4 clamp low 64K",   64'h0000_0000_01FF_0000, 2'd0, 6'd63, 6'd0,  2'd1, 2'd0, 1'b0, 1'b0);
        // R7 level cutoffs, each side
        for (int gc = 0; gc < 3; gc++) begin
            int ws[8];
            ws = '{48, 47, 43, 42, 40, 39, 31, 30};
            for (int k = 0; k < 8; k++) begin
                send("R7 level cutoff", 64'h0000_0000_0000_0000 | (64'h5A5A_A5A5_F0F0 & ((64'd1 << ws[k]) - 64'd1)),
                     2'd0, 6'(64 - ws[k]), 6'd16, 2'(gc), 2'd0, 1'b0, 1'b0);
            end
            send("R7 level cutoff 29", 64'h0000_0000_1555_5000, 2'd0, 6'd35, 6'd16, 2'(gc), 2'd0, 1'b0, 1'b0);
            send("R7 level cutoff 26", 64'h0000_0000_0355_5000, 2'd0, 6'd38, 6'd16, 2'(gc), 2'd0, 1'b0, 1'b0);
        end
        // R8 descriptor address with distinct bases
        tbl_lo_base = 48'hAAAA_5555_FFFF;
        send("R8 address lower",   64'h0000_7FFF_FFFF_F000, 2'd0, 6'd20, 6'd16, 2'd0, 2'd0, 1'b0, 1'b0);
        tbl_hi_base = 48'h0F0F_F0F0_3C3C;
        send("R8 address upper",   64'hFFFF_FFFF_8765_4000, 2'd0, 6'd16, 6'd30, 2'd0, 2'd1, 1'b0, 1'b0);
        // R6 higher tiers
        send("R6 ignores disable and range", 64'h0000_FFFF_0000_0000, 2'd1, 6'd30, 6'd16, 2'd0, 2'd0, 1'b1, 1'b1);
        send("R6 upper tag faults", 64'hFFFF_FFFF_0000_0000, 2'd2, 6'd16, 6'd16, 2'd0, 2'd3, 1'b0, 1'b0);
        send("R6 lower granule only", 64'h0000_1234_5678_0000, 2'd3, 6'd16, 6'd16, 2'd1, 2'd2, 1'b0, 1'b0);
        // R9 fault zeroes address
        send("R9 fault address",   64'h0001_0000_0000_0000, 2'd0, 6'd16, 6'd16, 2'd0, 2'd0, 1'b0, 1'b0);

        // pseudo-random mix under backpressure (R10 stall, reload, drain)
        bp_on = 1'b1;
        for (int n = 0; n < 200; n++) begin
            logic [63:0] va;
            logic [47:0] low;
            int          kind;
            kind = int'($urandom % 4);
            low  = 48'({$urandom, $urandom}) >> ($urandom % 24);
            tbl_lo_base = 48'({$urandom, $urandom});
            tbl_hi_base = 48'({$urandom, $urandom});
            case (kind)
                1:       va = {16'hFFFF, low | ~(48'hFFFF_FFFF_FFFF >> ($urandom % 24))};
                2:       va = {16'($urandom), low};
                default: va = {16'h0000, low};
            endcase
            send("R8 random mix", va, 2'($urandom), 6'($urandom), 6'($urandom),
                 2'($urandom), 2'($urandom), (($urandom % 8) == 0), (($urandom % 8) == 0));
        end

        bp_on = 1'b0;
        repeat (10) @(posedge clk);
        #1;
        check("R10 all results delivered", q_exp.size() == 0, 64'(q_exp.size()), 64'd0);
        done = 1'b1;
        finish_up();
    end

endmodule